// File: doc/BRIEF.md
# Gated Charge-Integration Channel Sequencer

This block is the digital controller for one pulse-height channel. It runs on its own and needs no other channel. A comparator flag from an analog threshold detector is brought into the clock domain and turned into a single trigger per rising crossing. Each trigger opens an integrator gate for a window that software sets. When the window closes, the block asks an 8-bit flash converter for one sample. It stores the returned code in a small per-channel FIFO, then holds the integrator in reset for a fixed short interval before it accepts the next trigger.

The host drains the FIFO through a valid/ready read port while the channel keeps writing. A code stays on `rd_data` until the host takes it: a transfer happens on a clock edge where both `rd_valid` and `rd_ready` are high. The FIFO never stalls the channel. If an event finishes while the FIFO is full, its code is dropped and a sticky overflow flag is set. Triggers that arrive while the channel is already busy start nothing. They are tallied in a saturating counter so that dead-time losses can be measured.

Top module: `pulse_channel_seq`

## Requirements
- R1: After reset, `busy`, `int_gate`, `conv_start`, `int_reset`, `rd_valid`, `overflow`, `fifo_count` and `dead_hits` are all zero.
- R2: The discriminator input passes through two synchroniser flops and a rising-edge detector. If `disc_in` goes high in cycle N, `int_gate` is low in cycle N+2 and high in cycle N+3. A level held high produces exactly one event.
- R3: `int_gate` stays high for exactly `int_len` cycles. Values below 10 are clamped to 10 and values above 300 to 300.
- R4: `conv_start` is a one-cycle pulse in the first cycle after `int_gate` falls. `int_gate`, `conv_start` and `int_reset` are never high together.
- R5: The `adc_data` value present in the cycle where `adc_valid` is high is written to the FIFO. The host reads codes in arrival order, and `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low.
- R6: Suppose `adc_valid` is high in cycle V. The code is written in cycle V+1, `int_reset` is high in cycles V+2 and V+3, and `busy` falls in cycle V+4. The dead time from `conv_start` to the fall of `busy` is therefore 6 cycles when the converter answers two cycles after `conv_start`.
- R7: `busy` is high in every phase except idle: integrate, convert, write and reset.
- R8: A rising crossing while `busy` is high starts no event and adds one to `dead_hits`. The counter saturates at all ones; its width is a parameter, 16 by default.
- R9: While `enable` is low, an idle channel ignores crossings and does not count them.
- R10: An event that completes with the FIFO full still runs the whole sequence, but its code is discarded and `overflow` is set. `fifo_full` is high when `fifo_count` equals the depth, which is 4 by default.
- R11: `overflow` stays set until a cycle with `ovf_clear` high. If a discard and `ovf_clear` fall in the same cycle, `overflow` ends up set.
- R12: `fifo_count` reports the number of stored codes and returns to 0 once the host has read them all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 10 ns tick |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows new events to start |
| disc_in | input | 1 | Asynchronous threshold-comparator flag |
| int_len | input | 9 | Integration window in clock ticks |
| adc_valid | input | 1 | Converter result strobe |
| adc_data | input | 8 | Converter result code |
| int_gate | output | 1 | Integrator enable gate |
| conv_start | output | 1 | Converter start pulse |
| int_reset | output | 1 | Integrator discharge |
| busy | output | 1 | Channel not able to accept a trigger |
| rd_valid | output | 1 | FIFO holds a code for the host |
| rd_ready | input | 1 | Host accepts the presented code |
| rd_data | output | 8 | Oldest stored code |
| fifo_full | output | 1 | FIFO at capacity |
| fifo_count | output | 3 | Number of stored codes |
| overflow | output | 1 | Sticky: a code was discarded |
| ovf_clear | input | 1 | Clears the overflow flag |
| dead_hits | output | 16 | Saturating count of triggers lost to busy |

## Verification
Two functions can land in the same cycle: the write phase that discards a code into a full FIFO and sets `overflow`, and a host pulse on `ovf_clear`. The converter model in the bench knows exactly which cycle is the write cycle, because it is the cycle after the one in which it raises `adc_valid`. It drives `ovf_clear` in that cycle while the FIFO is full and `overflow` is already set. A design where the clear wins would show `overflow` low afterwards, so the bench expects it to stay high and then checks that a lone clear drops it. A second overlap is also tested: retriggers that arrive during integration must be counted without starting a second event, and the scoreboard confirms that exactly one code results.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INTEG = 3'd1,
    ST_CONV  = 3'd2,
    ST_WRITE = 3'd3,
    ST_RESET = 3'd4
  } seq_state_t;
endpackage

// File: rtl/pcs_edge_sync.sv
module pcs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sh[0] <= 1'b0;
          else        sh[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sh[i] <= 1'b0;
          else        sh[i] <= sh[i-1];
        end
      end
    end
  endgenerate

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pcs_sequencer.sv
module pcs_sequencer
  import pcs_pkg::*;
#(
  parameter int LEN_W   = 9,
  parameter int LEN_MIN = 10,
  parameter int LEN_MAX = 300,
  parameter int RST_CYC = 2,
  parameter int CODE_W  = 8,
  parameter int HIT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              trig,
  input  logic [LEN_W-1:0]  int_len,
  input  logic              adc_valid,
  input  logic [CODE_W-1:0] adc_data,
  output logic              int_gate,
  output logic              conv_start,
  output logic              int_reset,
  output logic              busy,
  output logic              wr_en,
  output logic [CODE_W-1:0] wr_data,
  output logic [HIT_W-1:0]  dead_hits
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(LEN_MIN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(LEN_MAX);
  localparam logic [LEN_W-1:0] RST_L = LEN_W'(RST_CYC - 1);
  localparam logic [HIT_W-1:0] HIT_MAX = '1;

  seq_state_t        state;
  logic [LEN_W-1:0]  cnt;
  logic [LEN_W-1:0]  len_c;
  logic              conv_q;
  logic [CODE_W-1:0] code_q;

  // window length limited to the legal range
  always_comb begin
    if (int_len < MIN_L)      len_c = MIN_L;
    else if (int_len > MAX_L) len_c = MAX_L;
    else                      len_c = int_len;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      conv_q <= 1'b0;
      code_q <= '0;
    end else begin
      conv_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (enable && trig) begin
            state <= ST_INTEG;
            cnt   <= len_c - 1'b1;
          end
        end
        ST_INTEG: begin
          if (cnt == '0) begin
            state  <= ST_CONV;
            conv_q <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CONV: begin
          if (adc_valid && !conv_q) begin
            code_q <= adc_data;
            state  <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          state <= ST_RESET;
          cnt   <= RST_L;
        end
        ST_RESET: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // triggers lost while the channel is occupied
  always_ff @(posedge clk) begin
    if (!rst_n)
      dead_hits <= '0;
    else if (trig && state != ST_IDLE && dead_hits != HIT_MAX)
      dead_hits <= dead_hits + 1'b1;
  end

  assign int_gate   = (state == ST_INTEG);
  assign conv_start = conv_q;
  assign int_reset  = (state == ST_RESET);
  assign busy       = (state != ST_IDLE);
  assign wr_en      = (state == ST_WRITE);
  assign wr_data    = code_q;
endmodule

// File: rtl/pcs_fifo.sv
module pcs_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [W-1:0]               rd_data,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count,
  input  logic                       ovf_clear,
  output logic                       overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push, pop;

  assign full     = (count == FULL_C);
  assign rd_valid = (count != '0);
  assign push     = wr_en && !full;
  assign pop      = rd_valid && rd_ready;
  assign rd_data  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // a discard takes priority over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)                overflow <= 1'b0;
    else if (wr_en && full)    overflow <= 1'b1;
    else if (ovf_clear)        overflow <= 1'b0;
  end
endmodule

// File: rtl/pulse_channel_seq.sv
module pulse_channel_seq #(
  parameter int LEN_W   = 9,
  parameter int LEN_MIN = 10,
  parameter int LEN_MAX = 300,
  parameter int RST_CYC = 2,
  parameter int CODE_W  = 8,
  parameter int DEPTH   = 4,
  parameter int HIT_W   = 16,
  parameter int SYNC_N  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic                       disc_in,
  input  logic [LEN_W-1:0]           int_len,
  input  logic                       adc_valid,
  input  logic [CODE_W-1:0]          adc_data,
  output logic                       int_gate,
  output logic                       conv_start,
  output logic                       int_reset,
  output logic                       busy,
  output logic                       rd_valid,
  input  logic                       rd_ready,
  output logic [CODE_W-1:0]          rd_data,
  output logic                       fifo_full,
  output logic [$clog2(DEPTH+1)-1:0] fifo_count,
  output logic                       overflow,
  input  logic                       ovf_clear,
  output logic [HIT_W-1:0]           dead_hits
);
  logic              trig;
  logic              wr_en;
  logic [CODE_W-1:0] wr_data;

  pcs_edge_sync #(.STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (disc_in),
    .rise     (trig)
  );

  pcs_sequencer #(
    .LEN_W   (LEN_W),
    .LEN_MIN (LEN_MIN),
    .LEN_MAX (LEN_MAX),
    .RST_CYC (RST_CYC),
    .CODE_W  (CODE_W),
    .HIT_W   (HIT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .trig       (trig),
    .int_len    (int_len),
    .adc_valid  (adc_valid),
    .adc_data   (adc_data),
    .int_gate   (int_gate),
    .conv_start (conv_start),
    .int_reset  (int_reset),
    .busy       (busy),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .dead_hits  (dead_hits)
  );

  pcs_fifo #(.DEPTH(DEPTH), .W(CODE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .full      (fifo_full),
    .count     (fifo_count),
    .ovf_clear (ovf_clear),
    .overflow  (overflow)
  );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int CODE_W = 8,
  parameter int HIT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              int_gate,
  input logic              conv_start,
  input logic              int_reset,
  input logic              busy,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [CODE_W-1:0] rd_data,
  input logic              fifo_full,
  input logic              overflow,
  input logic              ovf_clear,
  input logic [HIT_W-1:0]  dead_hits
);
  a_r7_gate_busy: assert property (@(posedge clk) disable iff (!rst_n)
    int_gate |-> busy);

  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({int_gate, conv_start, int_reset}));

  a_r4_conv_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r4_conv_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_gate) |-> conv_start);

  a_r6_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(int_reset));

  a_r10_full_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> rd_valid);

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clear |=> overflow);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  a_r8_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> dead_hits >= $past(dead_hits));
endmodule

bind pulse_channel_seq pcs_checker #(.CODE_W(CODE_W), .HIT_W(HIT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .int_gate   (int_gate),
  .conv_start (conv_start),
  .int_reset  (int_reset),
  .busy       (busy),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .fifo_full  (fifo_full),
  .overflow   (overflow),
  .ovf_clear  (ovf_clear),
  .dead_hits  (dead_hits)
);

// File: tb/tb_pulse_channel_seq.sv
module tb_pulse_channel_seq;
  localparam int HW = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       disc_in = 1'b0;
  logic [8:0] int_len = 9'd20;
  logic       adc_valid = 1'b0;
  logic [7:0] adc_data = 8'h00;
  logic       int_gate, conv_start, int_reset, busy;
  logic       rd_valid;
  logic       rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic       fifo_full;
  logic [2:0] fifo_count;
  logic       overflow;
  logic       ovf_clear = 1'b0;
  logic [HW-1:0] dead_hits;

  pulse_channel_seq #(.HIT_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .disc_in(disc_in),
    .int_len(int_len), .adc_valid(adc_valid), .adc_data(adc_data),
    .int_gate(int_gate), .conv_start(conv_start), .int_reset(int_reset),
    .busy(busy), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .fifo_full(fifo_full), .fifo_count(fifo_count), .overflow(overflow),
    .ovf_clear(ovf_clear), .dead_hits(dead_hits)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] next_code = 8'h00;
  bit clr_now = 0;
  bit clr_at_write = 0;

  // monitor-side observations
  int gate_run = 0, last_gate = 0;
  int rst_run = 0, last_rst = 0;
  int conv_cnt = 0, conv_cyc = 0, fall_cyc = 0;
  logic prev_busy = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: samples 4 ns after each falling edge, before the rising edge
  initial begin
    forever begin
      @(negedge clk); #4;
      if (rst_n) begin
        if (rd_valid && rd_ready) begin
          if (exp_q.size() == 0) chk(0, "R5 unexpected code", int'(rd_data), -1);
          else begin
            chk(rd_data == exp_q[0], "R5 code order", int'(rd_data), int'(exp_q[0]));
            void'(exp_q.pop_front());
          end
        end
        if (int_gate) gate_run++;
        else if (gate_run > 0) begin last_gate = gate_run; gate_run = 0; end
        if (int_reset) rst_run++;
        else if (rst_run > 0) begin last_rst = rst_run; rst_run = 0; end
        if (conv_start) begin conv_cnt++; conv_cyc = cyc; end
        if (prev_busy && !busy) fall_cyc = cyc;
        prev_busy = busy;
      end
    end
  end

  // converter model: answers two cycles after conv_start, owns ovf_clear
  initial begin
    forever begin
      @(negedge clk);
      ovf_clear = 1'b0;
      if (clr_now) begin ovf_clear = 1'b1; clr_now = 0; end
      if (conv_start) begin
        @(negedge clk);
        ovf_clear = 1'b0;
        @(negedge clk);
        adc_valid = 1'b1;
        adc_data  = next_code;
        @(negedge clk);
        adc_valid = 1'b0;
        ovf_clear = clr_at_write;   // lands in the write cycle
        clr_at_write = 0;
      end
    end
  end

  task automatic wait_idle();
    int guard = 0;
    @(negedge clk);
    while (busy && guard < 2000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic fire(input logic [7:0] code, input bit keep);
    next_code = code;
    if (keep) exp_q.push_back(code);
    @(negedge clk); disc_in = 1'b1;
    repeat (4) @(negedge clk);
    disc_in = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int c0, h0;
    repeat (3) @(negedge clk);
    #4;
    // R1 reset state
    chk(!busy && !int_gate && !conv_start && !int_reset, "R1 outputs idle", int'(busy), 0);
    chk(!rd_valid && !overflow && fifo_count == 0, "R1 fifo clear", int'(fifo_count), 0);
    chk(dead_hits == 0, "R1 dead_hits", int'(dead_hits), 0);
    @(negedge clk); rst_n = 1'b1; enable = 1'b1; rd_ready = 1'b1;
    repeat (2) @(negedge clk);

    // R2 latency through the synchroniser, held level gives one event
    int_len = 9'd20; next_code = 8'h5A; exp_q.push_back(8'h5A);
    c0 = conv_cnt;
    disc_in = 1'b1;                       // cycle N
    @(negedge clk); @(negedge clk); #4;   // cycle N+2
    chk(!int_gate, "R2 gate low at N+2", int'(int_gate), 0);
    @(negedge clk); #4;                   // cycle N+3
    chk(int_gate, "R2 gate high at N+3", int'(int_gate), 1);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(conv_cnt == c0 + 1, "R2 held level one event", conv_cnt - c0, 1);
    chk(dead_hits == 0, "R2 held level no retrigger", int'(dead_hits), 0);
    disc_in = 1'b0;
    chk(last_gate == 20, "R3 window 20", last_gate, 20);
    chk(last_rst == 2, "R6 reset length", last_rst, 2);
    chk(fall_cyc - conv_cyc == 6, "R6 dead time", fall_cyc - conv_cyc, 6);
    repeat (3) @(negedge clk);

    // R3 clamping and window lengths, R5 several codes
    int_len = 9'd5;   fire(8'hFF, 1); chk(last_gate == 10,  "R3 clamp low",  last_gate, 10);
    int_len = 9'd400; fire(8'h00, 1); chk(last_gate == 300, "R3 clamp high", last_gate, 300);
    int_len = 9'd10;  fire(8'hA5, 1); chk(last_gate == 10,  "R3 window 10",  last_gate, 10);
    int_len = 9'd300; fire(8'h3C, 1); chk(last_gate == 300, "R3 window 300", last_gate, 300);
    chk(exp_q.size() == 0, "R5 all codes read", exp_q.size(), 0);

    // R8 retrigger during integration
    int_len = 9'd100; c0 = conv_cnt; next_code = 8'h11; exp_q.push_back(8'h11);
    disc_in = 1'b1; repeat (10) @(negedge clk);
    disc_in = 1'b0; repeat (3) @(negedge clk);
    disc_in = 1'b1; repeat (3) @(negedge clk);
    disc_in = 1'b0;
    wait_idle();
    chk(dead_hits == 1, "R8 retrigger counted", int'(dead_hits), 1);
    chk(conv_cnt == c0 + 1, "R8 one event only", conv_cnt - c0, 1);

    // R9 disabled channel ignores crossings
    enable = 1'b0; c0 = conv_cnt;
    disc_in = 1'b1; repeat (4) @(negedge clk); disc_in = 1'b0;
    repeat (20) @(negedge clk);
    chk(!busy && conv_cnt == c0, "R9 no event when disabled", conv_cnt - c0, 0);
    chk(dead_hits == 1, "R9 not counted", int'(dead_hits), 1);
    enable = 1'b1;

    // R8 saturation of the lost-trigger counter (width 6 here)
    int_len = 9'd300; next_code = 8'h22; exp_q.push_back(8'h22);
    disc_in = 1'b1; repeat (6) @(negedge clk);
    for (int i = 0; i < 70; i++) begin
      disc_in = 1'b0; repeat (2) @(negedge clk);
      disc_in = 1'b1; repeat (2) @(negedge clk);
    end
    disc_in = 1'b0;
    wait_idle();
    chk(dead_hits == 63, "R8 saturates", int'(dead_hits), 63);

    // R10 fill the FIFO then overflow
    rd_ready = 1'b0;
    fire(8'h81, 1); fire(8'h82, 1); fire(8'h83, 1); fire(8'h84, 1);
    chk(fifo_full && fifo_count == 4, "R10 full at depth", int'(fifo_count), 4);
    chk(!overflow, "R10 no overflow yet", int'(overflow), 0);
    c0 = conv_cnt; h0 = int'(fifo_count);
    fire(8'h85, 0);
    chk(conv_cnt == c0 + 1, "R10 sequence still runs", conv_cnt - c0, 1);
    chk(overflow, "R10 overflow set", int'(overflow), 1);
    chk(int'(fifo_count) == h0, "R10 code discarded", int'(fifo_count), h0);

    // R11 discard and clear in the same cycle: set wins
    clr_at_write = 1;
    fire(8'h86, 0);
    chk(overflow, "R11 set wins over clear", int'(overflow), 1);
    @(negedge clk); clr_now = 1;
    repeat (3) @(negedge clk);
    chk(!overflow, "R11 clear alone", int'(overflow), 0);

    // R12 drain: count returns to zero, order via scoreboard
    rd_ready = 1'b1;
    repeat (8) @(negedge clk);
    chk(fifo_count == 0 && !rd_valid, "R12 count zero after drain", int'(fifo_count), 0);
    chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule